// File: doc/BRIEF.md
# Quarter-Wave Twiddle Factor Generator

This block supplies the complex rotation coefficient W = cos(2πk/N) − j·sin(2πk/N) that a radix-2 butterfly engine needs for any index k in the range 0 to N/2−1. Only one table is stored. It holds the sine of the first quadrant, with N/4+1 entries for angles 2πm/N where m runs from 0 to N/4 and both endpoints are included. Both the real and the imaginary parts are read from this same table. The index is folded, and the sign is fixed after the lookup.

An address generator drives an index with a valid strobe. The coefficient appears on registered outputs in the next cycle, ready for the next butterfly. The table contents are computed at elaboration from the transform length and the output word width. Full scale is 2^(DW−1), and the value 1.0 is clamped to the largest positive code.

Top module: `qtw_gen`

## Requirements
- R1: While reset is asserted and after it is released, before the first valid index, `tw_vld_o`, `tw_re_o` and `tw_im_o` are all zero.
- R2: `tw_vld_o` is high in the cycle after a cycle in which `idx_vld_i` is high, and low in the cycle after a cycle in which `idx_vld_i` is low.
- R3: Index 0 gives exactly `tw_re_o` = 2^(DW−1)−1 and `tw_im_o` = 0.
- R4: Index N/4 gives exactly `tw_re_o` = 0 and `tw_im_o` = −(2^(DW−1)−1).
- R5: For every index k, the signed two's complement outputs are within one LSB of cos(2πk/N)·2^(DW−1) for `tw_re_o` and of −sin(2πk/N)·2^(DW−1) for `tw_im_o`.
- R6: `tw_im_o` is never positive. `tw_re_o` is non-negative for k < N/4 and non-positive for k > N/4.
- R7: While `idx_vld_i` is low, `tw_re_o` and `tw_im_o` keep their last values, whatever `idx_i` does.
- R8: For N/4 ≤ k < N/2, `tw_re_o` for index k equals exactly `tw_im_o` for index k−N/4.
- R9: Neither output ever carries the most negative code −2^(DW−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| idx_vld_i | input | 1 | Index strobe |
| idx_i | input | $clog2(N_PTS/2) | Twiddle index k |
| tw_vld_o | output | 1 | Coefficient valid, one cycle after the strobe |
| tw_re_o | output | DW | Real part, cos(2πk/N), signed |
| tw_im_o | output | DW | Imaginary part, −sin(2πk/N), signed |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing, the exact codes at k=0 and k=N/4, the sign of each output in each half-range, that the outputs hold while idle, and that the most negative code never appears. Some properties depend on the real-valued reference and on pairs of indices. These are the one-LSB accuracy at every index and the exact match between the real part at k and the imaginary part at k−N/4. Only the bench can show them, through full sweeps of a 256-point, 16-bit instance and a 16-point, 12-bit instance.

// File: rtl/qtw_pkg.sv
// Package qtw_pkg
// Holds the elaboration-time math that fills the quarter-wave table.
// Assumes the angle passed to qtw_sin_q lies in [0, pi/2].
package qtw_pkg;

    localparam real QTW_PI = 3.14159265358979323846;

    // Sine by a truncated Taylor series. Over [0, pi/2] the error stays far below 1e-9.
    function automatic real qtw_sin_q(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int i = 1; i < 12; i++) begin
            term = -term * x * x / ($itor(2 * i) * $itor(2 * i + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Signed code of sin(2*pi*m/n_pts), scaled by 2^(dw-1), rounded, clamped to the largest positive code.
    function automatic int qtw_code(input int m, input int n_pts, input int dw);
        real ang;
        real scaled;
        int  code;
        int  top;
        top    = (1 << (dw - 1)) - 1;
        ang    = 2.0 * QTW_PI * $itor(m) / $itor(n_pts);
        scaled = qtw_sin_q(ang) * $itor(1 << (dw - 1));
        code   = $rtoi(scaled + 0.5);
        if (code > top) code = top;
        if (code < 0)   code = 0;
        return code;
    endfunction

endpackage

// File: rtl/qtw_fold.sv
// Module qtw_fold
// Maps an index k in [0, N/2) to two addresses in the quarter table and a sign flag for the cosine.
// Assumes N_PTS is a power of two and at least 8. The top index bit selects the quadrant.
module qtw_fold #(
    parameter int N_PTS = 256,
    parameter int KW    = $clog2(N_PTS / 2),
    parameter int AW    = $clog2(N_PTS / 4 + 1)
) (
    input  logic [KW-1:0] idx_i,
    output logic [AW-1:0] cos_addr_o,
    output logic [AW-1:0] sin_addr_o,
    output logic          cos_neg_o
);

    localparam logic [AW-1:0] QTR_A = AW'(N_PTS / 4);

    logic          quad;
    logic [AW-1:0] low_a;
    logic [AW-1:0] mirror_a;

    // Split the index into its quadrant bit and its offset within the quadrant.
    always_comb begin
        quad     = idx_i[KW-1];
        low_a    = AW'(idx_i[KW-2:0]);
        mirror_a = QTR_A - low_a;
    end

    // First quadrant: cos reads N/4-k and sin reads k. Second quadrant: the two swap and cos is negated.
    always_comb begin
        if (quad) begin
            cos_addr_o = low_a;
            sin_addr_o = mirror_a;
            cos_neg_o  = 1'b1;
        end else begin
            cos_addr_o = mirror_a;
            sin_addr_o = low_a;
            cos_neg_o  = 1'b0;
        end
    end

endmodule

// File: rtl/qtw_qrom.sv
// Module qtw_qrom
// Constant first-quadrant sine table with two combinational read ports.
// It holds N/4+1 entries, filled at elaboration. An address past the last entry reads zero.
module qtw_qrom #(
    parameter int N_PTS = 256,
    parameter int DW    = 16,
    parameter int AW    = $clog2(N_PTS / 4 + 1)
) (
    input  logic [AW-1:0]        addr_a_i,
    input  logic [AW-1:0]        addr_b_i,
    output logic signed [DW-1:0] data_a_o,
    output logic signed [DW-1:0] data_b_o
);

    localparam int DEPTH = N_PTS / 4 + 1;

    logic signed [DW-1:0] rom [DEPTH];

    // One constant per entry, computed at elaboration.
    for (genvar m = 0; m < DEPTH; m++) begin : g_entry
        localparam int CODE = qtw_pkg::qtw_code(m, N_PTS, DW);
        assign rom[m] = DW'(CODE);
    end

    // Read port A, with a guard against addresses past the table.
    always_comb begin
        if (int'(addr_a_i) < DEPTH) data_a_o = rom[addr_a_i];
        else                        data_a_o = '0;
    end

    // Read port B, with the same guard.
    always_comb begin
        if (int'(addr_b_i) < DEPTH) data_b_o = rom[addr_b_i];
        else                        data_b_o = '0;
    end

endmodule

// File: rtl/qtw_ostage.sv
// Module qtw_ostage
// Applies the signs and registers the coefficient. It holds its value when no index is strobed.
// Assumes both magnitudes are non-negative and never exceed the largest positive code.
module qtw_ostage #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [DW-1:0] cos_mag_i,
    input  logic signed [DW-1:0] sin_mag_i,
    input  logic                 cos_neg_i,
    output logic                 vld_o,
    output logic signed [DW-1:0] re_o,
    output logic signed [DW-1:0] im_o
);

    logic signed [DW-1:0] re_d;
    logic signed [DW-1:0] im_d;

    // Sign fix: the real part flips in the second quadrant, and the imaginary part is always -sin.
    always_comb begin
        re_d = cos_neg_i ? -cos_mag_i : cos_mag_i;
        im_d = -sin_mag_i;
    end

    // Output register: the strobe moves forward every cycle, and the data loads only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            re_o  <= '0;
            im_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                re_o <= re_d;
                im_o <= im_d;
            end
        end
    end

endmodule

// File: rtl/qtw_gen.sv
// Module qtw_gen
// Twiddle generator for a radix-2 engine. It returns W_N^k for k in [0, N/2) one cycle after the index.
// Assumes N_PTS is a power of two of at least 8 and DW of at least 4.
module qtw_gen #(
    parameter int N_PTS = 256,
    parameter int DW    = 16,
    parameter int KW    = $clog2(N_PTS / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_vld_i,
    input  logic [KW-1:0]        idx_i,
    output logic                 tw_vld_o,
    output logic signed [DW-1:0] tw_re_o,
    output logic signed [DW-1:0] tw_im_o
);

    localparam int AW = $clog2(N_PTS / 4 + 1);

    logic [AW-1:0]        cos_addr;
    logic [AW-1:0]        sin_addr;
    logic                 cos_neg;
    logic signed [DW-1:0] cos_mag;
    logic signed [DW-1:0] sin_mag;

    qtw_fold #(.N_PTS(N_PTS), .KW(KW), .AW(AW)) fold_i (
        .idx_i      (idx_i),
        .cos_addr_o (cos_addr),
        .sin_addr_o (sin_addr),
        .cos_neg_o  (cos_neg)
    );

    qtw_qrom #(.N_PTS(N_PTS), .DW(DW), .AW(AW)) rom_i (
        .addr_a_i (cos_addr),
        .addr_b_i (sin_addr),
        .data_a_o (cos_mag),
        .data_b_o (sin_mag)
    );

    qtw_ostage #(.DW(DW)) ost_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (idx_vld_i),
        .cos_mag_i (cos_mag),
        .sin_mag_i (sin_mag),
        .cos_neg_i (cos_neg),
        .vld_o     (tw_vld_o),
        .re_o      (tw_re_o),
        .im_o      (tw_im_o)
    );

endmodule

// File: rtl/qtw_gen_chk.sv
// Module qtw_gen_chk
// Cycle-level properties of qtw_gen, attached to every instance by the bind below.
module qtw_gen_chk #(
    parameter int N_PTS = 256,
    parameter int DW    = 16,
    parameter int KW    = $clog2(N_PTS / 2)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 idx_vld_i,
    input logic [KW-1:0]        idx_i,
    input logic                 tw_vld_o,
    input logic signed [DW-1:0] tw_re_o,
    input logic signed [DW-1:0] tw_im_o
);

    localparam int                   QTR  = N_PTS / 4;
    localparam logic signed [DW-1:0] PMAX = DW'((1 << (DW - 1)) - 1);
    localparam logic signed [DW-1:0] NMAX = -PMAX;
    localparam logic signed [DW-1:0] MINC = {1'b1, {(DW-1){1'b0}}};

    // R2
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_vld_i |=> tw_vld_o);
    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_vld_i |=> !tw_vld_o);
    // R3
    unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_vld_i && int'(idx_i) == 0) |=> (tw_re_o == PMAX && tw_im_o == '0));
    // R4
    neg_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_vld_i && int'(idx_i) == QTR) |=> (tw_re_o == '0 && tw_im_o == NMAX));
    // R6
    im_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_vld_o |-> tw_im_o <= 0);
    // R6
    re_q0_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_vld_i && int'(idx_i) < QTR) |=> tw_re_o >= 0);
    // R6
    re_q1_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_vld_i && int'(idx_i) > QTR) |=> tw_re_o <= 0);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_vld_i |=> ($stable(tw_re_o) && $stable(tw_im_o)));
    // R9
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_re_o != MINC && tw_im_o != MINC));

endmodule

bind qtw_gen qtw_gen_chk #(.N_PTS(N_PTS), .DW(DW), .KW(KW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_vld_i (idx_vld_i),
    .idx_i     (idx_i),
    .tw_vld_o  (tw_vld_o),
    .tw_re_o   (tw_re_o),
    .tw_im_o   (tw_im_o)
);

// File: tb/qtw_gen_tb_top.sv
`timescale 1ns/1ps
module qtw_gen_tb_top;

    localparam int NB  = 256;
    localparam int DB  = 16;
    localparam int KB  = $clog2(NB / 2);
    localparam int NS  = 16;
    localparam int DS  = 12;
    localparam int KS  = $clog2(NS / 2);
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 b_vld = 1'b0;
    logic [KB-1:0]        b_idx = '0;
    logic                 b_ov;
    logic signed [DB-1:0] b_re, b_im;
    logic                 s_vld = 1'b0;
    logic [KS-1:0]        s_idx = '0;
    logic                 s_ov;
    logic signed [DS-1:0] s_re, s_im;

    qtw_gen #(.N_PTS(NB), .DW(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .idx_vld_i(b_vld), .idx_i(b_idx),
        .tw_vld_o(b_ov), .tw_re_o(b_re), .tw_im_o(b_im));

    qtw_gen #(.N_PTS(NS), .DW(DS)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .idx_vld_i(s_vld), .idx_i(s_idx),
        .tw_vld_o(s_ov), .tw_re_o(s_re), .tw_im_o(s_im));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int re_l [NB/2];
    int im_l [NB/2];

    task automatic tally(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Checks one returned coefficient against the real-valued reference and the exact points.
    task automatic check_pt(input string cfg, input int n, input int dw, input int k,
                            input logic v, input int re, input int im);
        real sc, er, ei, dr, di;
        int  pmax;
        sc   = $itor(1 << (dw - 1));
        pmax = (1 << (dw - 1)) - 1;
        er   = $cos(2.0 * PI * $itor(k) / $itor(n)) * sc;
        ei   = -$sin(2.0 * PI * $itor(k) / $itor(n)) * sc;
        dr   = $itor(re) - er;
        di   = $itor(im) - ei;
        tally(v == 1'b1, "R2", {cfg, " valid one cycle after index"}, int'(v), 1);
        tally(dr <= 1.0 && dr >= -1.0, "R5", {cfg, " real part"}, re, $rtoi(er));
        tally(di <= 1.0 && di >= -1.0, "R5", {cfg, " imag part"}, im, $rtoi(ei));
        tally(im <= 0, "R6", {cfg, " imag sign"}, im, 0);
        if (k < n / 4) tally(re >= 0, "R6", {cfg, " real sign q0"}, re, 0);
        if (k > n / 4) tally(re <= 0, "R6", {cfg, " real sign q1"}, re, 0);
        if (k == 0) begin
            tally(re == pmax, "R3", {cfg, " real at k=0"}, re, pmax);
            tally(im == 0,    "R3", {cfg, " imag at k=0"}, im, 0);
        end
        if (k == n / 4) begin
            tally(re == 0,     "R4", {cfg, " real at k=N/4"}, re, 0);
            tally(im == -pmax, "R4", {cfg, " imag at k=N/4"}, im, -pmax);
        end
        tally(re != -(pmax + 1) && im != -(pmax + 1), "R9", {cfg, " most negative code"}, re, im);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tally(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int hold_re, hold_im;
        repeat (3) @(negedge clk);
        // R1: outputs of both instances are zero during reset
        tally(b_ov == 1'b0 && s_ov == 1'b0, "R1", "valid in reset", int'(b_ov) + int'(s_ov), 0);
        tally(b_re == 0 && b_im == 0, "R1", "big data in reset", int'(b_re), 0);
        tally(s_re == 0 && s_im == 0, "R1", "small data in reset", int'(s_re), 0);
        rst_n = 1'b1;
        @(negedge clk);
        tally(b_ov == 1'b0 && b_re == 0 && b_im == 0, "R1", "big after release", int'(b_re), 0);

        // Full sweep of the 256-point instance, with the index strobed every cycle.
        b_vld = 1'b1;
        b_idx = '0;
        for (int k = 0; k < NB / 2; k++) begin
            @(negedge clk);
            check_pt("N256", NB, DB, k, b_ov, int'(b_re), int'(b_im));
            re_l[k] = int'(b_re);
            im_l[k] = int'(b_im);
            if (k < NB / 2 - 1) b_idx = KB'(k + 1);
            else                b_vld = 1'b0;
        end
        hold_re = re_l[NB/2-1];
        hold_im = im_l[NB/2-1];

        // R8: exact reuse of one table between the two parts
        for (int k = NB / 4; k < NB / 2; k++)
            tally(re_l[k] == im_l[k - NB/4], "R8", "real(k) vs imag(k-N/4)", re_l[k], im_l[k - NB/4]);

        // R7: outputs hold while idle, even though the index keeps moving
        for (int j = 0; j < 6; j++) begin
            b_idx = KB'(j * 17);
            @(negedge clk);
            tally(b_ov == 1'b0, "R2", "valid low after idle", int'(b_ov), 0);
            tally(int'(b_re) == hold_re, "R7", "real held", int'(b_re), hold_re);
            tally(int'(b_im) == hold_im, "R7", "imag held", int'(b_im), hold_im);
        end

        // Sweep of the 16-point, 12-bit instance in descending order, with idle gaps.
        for (int k = NS / 2 - 1; k >= 0; k--) begin
            s_vld = 1'b1;
            s_idx = KS'(k);
            @(negedge clk);
            s_vld = 1'b0;
            s_idx = KS'(NS / 4);
            check_pt("N16", NS, DS, k, s_ov, int'(s_re), int'(s_im));
            @(negedge clk);
            tally(s_ov == 1'b0, "R2", "N16 valid after gap", int'(s_ov), 0);
        end

        finish_run();
    end

endmodule